// File: doc/BRIEF.md
# Dual-Compare Timer with Per-Channel Action Masks

The block is an 8-bit up-counter whose count input is picked from four candidate enable sources by a 2-bit select field. Two compare channels watch the count. Each channel has its own compare value and its own 4-bit action mask. When the count equals a channel's compare value on a counting cycle, that channel produces a match event. Depending on its mask, the event clears the counter, inverts a shared output flip-flop, sets a sticky interrupt flag, and can take part in a one-shot scheme that silences the channel after its first hit. A per-channel match strobe is exposed so that a following counter stage can use it as a count enable.

Software reaches the compare values, the action masks, the clock-select field, the interrupt flags and the live count through a flat write/read register port. Each channel holds a small one-shot state machine with three states. OS_FREE means continuous compare, with the single-action bit clear. OS_ARMED means single-action is on and the channel has not yet hit. OS_SPENT means single-action is on and the channel has already hit, so it is silenced. The transitions are named as follows. T_ARM goes from any state to OS_ARMED when the mask is written with the single-action bit set. T_FREE goes from any state to OS_FREE when the mask is written with that bit clear. T_REARM goes from OS_ARMED or OS_SPENT to OS_ARMED when the compare value is written. T_FIRE goes from OS_ARMED to OS_SPENT on a hit. A mask write takes priority over a compare write, and both take priority over T_FIRE.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count is 0, toggle_o is 0, irq_o is 0, match_o is 00, both compare values are 0, both masks are 0000 and the clock select reads 11.
- R2: The count rises by exactly 1 (wrapping 255 to 0) on each clock where the selected enable is high, and holds otherwise. The clock select encoding is: 11 uses src_en_i[3], 10 uses src_en_i[2], 01 uses src_en_i[1], and 00 uses the external input.
- R3: With select 00, src_en_i[0] is a raw external level that passes through a two-flop synchronizer and a rising-edge detector. Each rising edge advances the count once, on the third clock edge after the level changes. A held high level adds nothing more.
- R4: A match event occurs on a counting cycle where the count equals a channel's compare value and that channel is not in OS_SPENT. match_o[ch] is high for exactly the one clock that follows the event, whatever the mask.
- R5: With mask bit 1 (counter clear) set, a match event loads 0 in place of the increment, so a compare value N gives a match every N+1 counts. A clear from either channel wins over the increment.
- R6: With mask bit 2 (toggle) set, a match event inverts toggle_o on the same edge that raises match_o. When both channels have toggle events in one cycle, toggle_o inverts only once.
- R7: With mask bit 0 (interrupt) set, a match event sets that channel's sticky flag. irq_o is the OR of both flags. Writing 1 to bit ch at address 5 clears flag ch, a set in the same cycle wins, and address 5 reads back the flags in bits 1:0.
- R8: With mask bit 3 (single-action) set, only the first match after arming produces an event. Later hits give no strobe and no action until the channel is re-armed by writing its mask with bit 3 set or by writing its compare value. Writing its mask with bit 3 clear returns it to continuous compare.
- R9: Register addresses are: 0 compare 0, 1 compare 1, 2 mask 0, 3 mask 1, 4 clock select (bits 1:0), 5 interrupt flags, 6 count (read only). The mask and select registers read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_en_i | input | 4 | Candidate count enables; bit 0 is the raw external level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| toggle_o | output | 1 | Shared output flip-flop |
| irq_o | output | 1 | OR of the two sticky interrupt flags |
| match_o | output | 2 | Per-channel match strobe, one clock per event |

## Verification
If a channel's one-shot state is wrong, a strobe appears or goes missing on match_o on the clock after the next equal count. For a free-running count, that is within one count period. A wrong count or a missed clear shows up at once in the read-back count, and it also shifts every later match. A toggle or flag update that is missed or doubled shows on toggle_o or irq_o on the same edge as the strobe. A bench model that runs in lockstep therefore catches each of these faults within one clock of the event that exposes it.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;
    localparam int NUM_CH  = 2;
    localparam int ADDR_W  = 3;
    localparam int MODE_W  = 4;

    localparam logic [ADDR_W-1:0] A_CMP0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_MSK0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_MSK1 = 3'd3;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;

    typedef enum logic [1:0] {
        OS_FREE  = 2'd0,
        OS_ARMED = 2'd1,
        OS_SPENT = 2'd2
    } os_state_t;

    typedef struct packed {
        logic single;
        logic tog;
        logic clr;
        logic irq;
    } act_mask_t;
endpackage

// File: rtl/dct_clk_sel.sv
module dct_clk_sel
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               cnt_en_o
);
    logic [SYNC_STAGES:0] shreg;
    logic                 ext_rise;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SYNC_STAGES-1:0], src_en_i[0]};
        end
    end

    assign ext_rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

    always_comb begin
        unique case (sel_i)
            2'b11:   cnt_en_o = src_en_i[3];
            2'b10:   cnt_en_o = src_en_i[2];
            2'b01:   cnt_en_o = src_en_i[1];
            default: cnt_en_o = ext_rise;
        endcase
    end
endmodule

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cmp_wr_i,
    input  logic             msk_wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_en_i,
    output logic [CNT_W-1:0] cmp_o,
    output act_mask_t        msk_o,
    output logic             ev_o,
    output logic             clr_req_o,
    output logic             tog_req_o,
    output logic             irq_req_o,
    output logic             spent_o
);
    os_state_t st_q, st_d;
    logic      hit;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cmp_o <= '0;
            msk_o <= '0;
        end else begin
            if (cmp_wr_i) cmp_o <= wr_data_i;
            if (msk_wr_i) msk_o <= act_mask_t'(wr_data_i[MODE_W-1:0]);
        end
    end

    assign hit = cnt_en_i && (cnt_i == cmp_o);

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= OS_FREE;
        else       st_q <= st_d;
    end

    // transitions: T_ARM / T_FREE, then T_REARM, then T_FIRE
    always_comb begin
        st_d = st_q;
        if (msk_wr_i) begin
            st_d = wr_data_i[MODE_W-1] ? OS_ARMED : OS_FREE;
        end else if (cmp_wr_i && st_q != OS_FREE) begin
            st_d = OS_ARMED;
        end else begin
            unique case (st_q)
                OS_FREE:  st_d = OS_FREE;
                OS_ARMED: st_d = hit ? OS_SPENT : OS_ARMED;
                OS_SPENT: st_d = OS_SPENT;
                default:  st_d = OS_FREE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ev_o      = 1'b0;
        spent_o   = 1'b0;
        unique case (st_q)
            OS_FREE:  ev_o = hit;
            OS_ARMED: ev_o = hit;
            OS_SPENT: spent_o = 1'b1;
            default:  ev_o = 1'b0;
        endcase
        clr_req_o = ev_o & msk_o.clr;
        tog_req_o = ev_o & msk_o.tog;
        irq_req_o = ev_o & msk_o.irq;
    end
endmodule

// File: rtl/dct_action.sv
module dct_action
    import dct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cnt_en_i,
    input  logic [NUM_CH-1:0] ev_i,
    input  logic [NUM_CH-1:0] clr_req_i,
    input  logic [NUM_CH-1:0] tog_req_i,
    input  logic [NUM_CH-1:0] irq_req_i,
    input  logic              flag_wr_i,
    input  logic [NUM_CH-1:0] flag_clr_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              toggle_o,
    output logic [NUM_CH-1:0] flags_o,
    output logic [NUM_CH-1:0] match_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o    <= '0;
            toggle_o <= 1'b0;
            match_o  <= '0;
        end else begin
            if (cnt_en_i) cnt_o <= (|clr_req_i) ? '0 : cnt_o + 1'b1;
            if (|tog_req_i) toggle_o <= ~toggle_o;
            match_o <= ev_i;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (rst_i)                         flags_o[c] <= 1'b0;
            else if (irq_req_i[c])             flags_o[c] <= 1'b1;
            else if (flag_wr_i && flag_clr_i[c]) flags_o[c] <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [3:0]        src_en_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              toggle_o,
    output logic              irq_o,
    output logic [1:0]        match_o
);
    logic [SEL_W-1:0]  sel_q;
    logic              cnt_en;
    logic [CNT_W-1:0]  cnt;
    logic [NUM_CH-1:0] cmp_wr, msk_wr, ev, clr_req, tog_req, irq_req, spent, flags;
    logic [CNT_W-1:0]  cmp_val [NUM_CH];
    act_mask_t         msk_val [NUM_CH];
    logic              clr_wr;

    assign cmp_wr[0] = wr_en_i && wr_addr_i == A_CMP0;
    assign cmp_wr[1] = wr_en_i && wr_addr_i == A_CMP1;
    assign msk_wr[0] = wr_en_i && wr_addr_i == A_MSK0;
    assign msk_wr[1] = wr_en_i && wr_addr_i == A_MSK1;
    assign clr_wr    = wr_en_i && wr_addr_i == A_FLAG;

    always_ff @(posedge clk_i) begin
        if (rst_i)                              sel_q <= '1;
        else if (wr_en_i && wr_addr_i == A_SEL) sel_q <= wr_data_i[SEL_W-1:0];
    end

    dct_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) clk_sel_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .src_en_i (src_en_i),
        .sel_i    (sel_q),
        .cnt_en_o (cnt_en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dct_channel #(.CNT_W(CNT_W)) ch_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .cmp_wr_i  (cmp_wr[c]),
            .msk_wr_i  (msk_wr[c]),
            .wr_data_i (wr_data_i),
            .cnt_i     (cnt),
            .cnt_en_i  (cnt_en),
            .cmp_o     (cmp_val[c]),
            .msk_o     (msk_val[c]),
            .ev_o      (ev[c]),
            .clr_req_o (clr_req[c]),
            .tog_req_o (tog_req[c]),
            .irq_req_o (irq_req[c]),
            .spent_o   (spent[c])
        );
    end

    dct_action #(.CNT_W(CNT_W)) action_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cnt_en_i   (cnt_en),
        .ev_i       (ev),
        .clr_req_i  (clr_req),
        .tog_req_i  (tog_req),
        .irq_req_i  (irq_req),
        .flag_wr_i  (clr_wr),
        .flag_clr_i (wr_data_i[NUM_CH-1:0]),
        .cnt_o      (cnt),
        .toggle_o   (toggle_o),
        .flags_o    (flags),
        .match_o    (match_o)
    );

    assign irq_o = |flags;

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_CMP0:  rd_data_o = cmp_val[0];
            A_CMP1:  rd_data_o = cmp_val[1];
            A_MSK0:  rd_data_o[MODE_W-1:0] = msk_val[0];
            A_MSK1:  rd_data_o[MODE_W-1:0] = msk_val[1];
            A_SEL:   rd_data_o[SEL_W-1:0] = sel_q;
            A_FLAG:  rd_data_o[NUM_CH-1:0] = flags;
            A_CNT:   rd_data_o = cnt;
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             cnt_en,
    input logic [CNT_W-1:0] cnt,
    input logic             toggle_o,
    input logic [1:0]       match_o,
    input logic [1:0]       flags,
    input logic             clr_wr,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [1:0]       spent
);
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(cnt_en) |-> $stable(cnt)); // R2
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(cnt_en) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0)); // R5
    AST_MATCH_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        (|match_o) |-> $past(cnt_en)); // R4
    AST_TOG_ON_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(toggle_o) |-> (|match_o)); // R6

    for (genvar c = 0; c < 2; c++) begin : g_c
        AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
            ($past(flags[c]) && !($past(clr_wr) && $past(wr_data_i[c]))) |-> flags[c]); // R7
        AST_SPENT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
            $past(spent[c]) |-> !match_o[c]); // R8
    end
endmodule

bind dual_cmp_timer dct_checker #(.CNT_W(CNT_W)) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cnt_en    (cnt_en),
    .cnt       (cnt),
    .toggle_o  (toggle_o),
    .match_o   (match_o),
    .flags     (flags),
    .clr_wr    (clr_wr),
    .wr_data_i (wr_data_i),
    .spent     (spent)
);

// File: tb/dual_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] src;
    logic       wr_en;
    logic [2:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       tog, irq;
    logic [1:0] match;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_cmp_timer dut_i (
        .clk_i(clk), .rst_i(rst), .src_en_i(src), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .toggle_o(tog), .irq_o(irq), .match_o(match)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_cnt;
    logic [7:0] m_cmp [2];
    logic [3:0] m_msk [2];
    int         m_st  [2];   // 0 free, 1 armed, 2 spent
    logic [1:0] m_sel, m_flag, m_match;
    logic       m_tog;
    logic [2:0] m_sh;

    function automatic logic f_en(logic [1:0] s, logic [3:0] e, logic [2:0] sh);
        case (s)
            2'd3: return e[3];
            2'd2: return e[2];
            2'd1: return e[1];
            default: return sh[1] & ~sh[2];
        endcase
    endfunction

    function automatic int f_next_st(int st, logic mw, logic [3:0] md, logic cw, logic hit);
        if (mw) return md[3] ? 1 : 0;
        if (cw && st != 0) return 1;
        if (st == 1 && hit) return 2;
        return st;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_tog = 0; m_flag = 0; m_match = 0; m_sel = 2'b11; m_sh = 0;
            for (int c = 0; c < 2; c++) begin m_cmp[c] = 0; m_msk[c] = 0; m_st[c] = 0; end
        end else begin
            logic en, anyclr, anytog;
            logic [1:0] hit, ev;
            en = f_en(m_sel, src, m_sh);
            anyclr = 0; anytog = 0;
            for (int c = 0; c < 2; c++) begin
                hit[c] = en && (m_cnt == m_cmp[c]);
                ev[c]  = hit[c] && (m_st[c] != 2);
                if (ev[c] && m_msk[c][1]) anyclr = 1;
                if (ev[c] && m_msk[c][2]) anytog = 1;
            end
            if (en) m_cnt = anyclr ? 8'd0 : m_cnt + 8'd1;
            if (anytog) m_tog = ~m_tog;
            m_match = ev;
            for (int c = 0; c < 2; c++) begin
                if (ev[c] && m_msk[c][0]) m_flag[c] = 1;
                else if (wr_en && wr_addr == 3'd5 && wr_data[c]) m_flag[c] = 0;
                m_st[c] = f_next_st(m_st[c], wr_en && wr_addr == 3'(2 + c), wr_data[3:0],
                                    wr_en && wr_addr == 3'(c), hit[c]);
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_cmp[0] = wr_data;
                    3'd1: m_cmp[1] = wr_data;
                    3'd2: m_msk[0] = wr_data[3:0];
                    3'd3: m_msk[1] = wr_data[3:0];
                    3'd4: m_sel    = wr_data[1:0];
                    default: ;
                endcase
            end
            m_sh = {m_sh[1:0], src[0]};
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // lockstep comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            if (rd_addr == 3'd6) chk("R2", "count vs model", rd_data, m_cnt);
            chk("R4", "match_o vs model", match, m_match);
            chk("R6", "toggle_o vs model", tog, m_tog);
            chk("R7", "irq_o vs model", irq, |m_flag);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #2 d = rd_data;
        rd_addr = 3'd6;
    endtask

    task automatic sample();
        @(negedge clk);
        #2;
    endtask

    initial begin
        logic [7:0] v, c0;
        int n, gap;
        logic pt;
        bit seen;
        void'($urandom(32'd20240611));
        rst = 1; src = 4'b1000; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 3'd6;
        repeat (3) @(negedge clk);
        src = 4'b0000;
        rst = 0;

        // R1 reset state
        sample();
        chk("R1", "toggle_o", tog, 0);
        chk("R1", "irq_o", irq, 0);
        chk("R1", "match_o", match, 0);
        chk("R1", "count", rd_data, 0);
        for (int a = 0; a < 4; a++) begin rd(3'(a), v); chk("R1", "cmp/mask reset", v, 0); end
        rd(3'd4, v); chk("R1", "select reset", v, 3);

        // R9 register map
        wr(3'd0, 8'h5A); wr(3'd1, 8'hA5); wr(3'd2, 8'hF3); wr(3'd3, 8'h06); wr(3'd4, 8'hFE);
        rd(3'd0, v); chk("R9", "cmp0 readback", v, 8'h5A);
        rd(3'd1, v); chk("R9", "cmp1 readback", v, 8'hA5);
        rd(3'd2, v); chk("R9", "mask0 readback", v, 8'h03);
        rd(3'd3, v); chk("R9", "mask1 readback", v, 8'h06);
        rd(3'd4, v); chk("R9", "select readback", v, 8'h02);
        wr(3'd2, 0); wr(3'd3, 0);

        // R2 selected source only
        src = 4'b1011; repeat (20) sample();
        rd(3'd6, c0);
        src = 4'b1111;
        repeat (10) @(negedge clk);
        src = 4'b1011;
        repeat (3) sample();
        chk("R2", "ten enables on source 2", rd_data, 8'(c0 + 8'd10));

        // R3 external edges, others high but unselected
        wr(3'd4, 8'h00);
        src = 4'b1110; repeat (5) sample();
        c0 = rd_data;
        for (int k = 0; k < 5; k++) begin
            src[0] = 1; repeat (3) @(negedge clk);
            src[0] = 0; repeat (3) @(negedge clk);
        end
        src[0] = 1; repeat (8) @(negedge clk);
        sample();
        chk("R3", "one count per rising edge", rd_data, 8'(c0 + 8'd6));

        // R5 period N+1
        wr(3'd4, 8'h03); src = 4'b1000;
        wr(3'd0, 8'd4); wr(3'd2, 8'b0010);
        n = 0; while (!match[0] && n < 600) begin sample(); n++; end
        gap = 0; sample(); gap = 1;
        while (!match[0] && gap < 600) begin sample(); gap++; end
        chk("R5", "clear-on-match period", gap, 5);

        // R6 both channels toggle once
        wr(3'd0, 8'd3); wr(3'd1, 8'd3); wr(3'd3, 8'b0100); wr(3'd2, 8'b0110);
        seen = 0; pt = tog;
        for (int k = 0; k < 40; k++) begin
            sample();
            if (match == 2'b11) begin
                seen = 1;
                chk("R6", "single inversion on double match", tog, !pt);
            end
            pt = tog;
        end
        chk("R6", "double match observed", seen, 1);

        // R8 single action, R7 interrupt flag
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h03);
        wr(3'd0, 8'd7); wr(3'd2, 8'b1001);
        n = 0; for (int k = 0; k < 600; k++) begin sample(); if (match[0]) n++; end
        chk("R8", "one strobe while armed", n, 1);
        chk("R7", "flag set after match", irq, 1);
        rd(3'd5, v); chk("R7", "flag readback", v, 1);
        wr(3'd5, 8'h01); sample();
        chk("R7", "flag cleared by write", irq, 0);
        wr(3'd0, 8'd7);
        n = 0; for (int k = 0; k < 300; k++) begin sample(); if (match[0]) n++; end
        chk("R8", "re-armed by compare write", n, 1);
        wr(3'd2, 8'b0001);
        n = 0; for (int k = 0; k < 600; k++) begin sample(); if (match[0]) n++; end
        chk("R8", "continuous after single cleared", n >= 2, 1);

        // constrained random, checked by the lockstep model
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            src = {($urandom % 4) != 0, 3'($urandom)};
            if (($urandom % 8) == 0) begin
                wr_en = 1;
                wr_addr = 3'($urandom % 6);
                wr_data = (wr_addr < 3'd2) ? 8'($urandom % 24) : 8'($urandom);
            end else begin
                wr_en = 0;
            end
        end
        @(negedge clk); wr_en = 0;
        repeat (4) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule